// File: doc/BRIEF.md
# Dual-Channel Drive Interrupt Collector

This block gathers interrupt requests for two disk-drive channels and presents them to a host through a small byte-wide register bus. Each channel has two request sources: the drive's own interrupt line, which is a level, and a completion event from the channel's bus-master transfer engine, which arrives as a pulse. The block records both, applies a per-channel mask, and drives one registered interrupt pin per channel whose active level is chosen by software.

Channel 0 status is read at offset 2. That address is shared with a write-only mode byte, so a host write there never reaches the status. Channel 1 status sits at offset 3, next to the two mask bits and a read-back of a board strap. Offset 1 holds the per-channel polarity selects. The transfer-complete status is sticky, and it is cleared by a dedicated clear pulse per channel rather than through the register bus.

Top module: `ide_irq_collect`

## Requirements
- R1: After a synchronous reset the masks, polarity selects, mode outputs and both status bits of each channel are 0, `irq_pin` is 2'b00 and `rd_data` is 0.
- R2: A read of offset 2 returns {6'b0, channel 0 transfer-complete status, channel 0 drive status}. Bit 1 is transfer-complete, bit 0 is drive, and 1 means asserted.
- R3: A write to offset 2 never changes any status bit. If write data bit 7 is 1, `legacy_mode` takes bit 1 and `test_mode` takes bit 0. If bit 7 is 0, the write is ignored.
- R4: A read of offset 3 returns bits 7..5 as 0, bit 4 = `legacy_strap`, bit 3 = channel 1 transfer-complete status, bit 2 = channel 1 drive status, bit 1 = channel 1 mask, and bit 0 = channel 0 mask.
- R5: A write to offset 3 loads only the mask bits from bits 1..0, where 1 means masked. Written values in bits 3..2 have no effect on the status.
- R6: A channel's drive status equals its `drv_irq` level sampled at the previous clock edge.
- R7: A channel's transfer-complete status is set by a `xfer_done` pulse. It stays set until a `xfer_clr` pulse. If both arrive in the same cycle, the set wins.
- R8: While a channel is masked, its `irq_pin` stays at the inactive level, and its status bits keep recording requests.
- R9: Offset 1 bits 1..0 are the polarity selects for channels 1..0, readable back with bits 7..2 as 0. A value of 1 means active low and 0 means active high.
- R10: `irq_pin[c]` is registered. It equals polarity XOR ((drive status OR transfer-complete status) AND NOT mask), all taken from the previous cycle.
- R11: `rd_data` holds the addressed byte in the cycle after `rd_en` is high, and is 0 after any cycle without `rd_en`. A read of offset 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| drv_irq | input | 2 | Drive interrupt level, one per channel |
| xfer_done | input | 2 | Transfer-complete pulse, one per channel |
| xfer_clr | input | 2 | Clear pulse for transfer-complete status |
| legacy_strap | input | 1 | Board strap reported in offset 3 bit 4 |
| legacy_mode | output | 1 | Mode bit loaded from offset 2 bit 1 |
| test_mode | output | 1 | Mode bit loaded from offset 2 bit 0 |
| irq_pin | output | 2 | Combined interrupt output, one per channel |

## Verification
The drive lines are driven with slow toggles and with single-cycle glitches. These patterns separate a status bit that follows the level from one that latches it. Transfer-complete pulses are applied alone, with a clear in a later cycle, and with a clear in the same cycle. This exposes a sticky bit that fails to hold, fails to clear, or loses the set/clear race. Mask and polarity are changed while requests are pending, to show that masking gates only the pin and not the recorded status. Writes to offset 2 with bit 7 set and clear, and writes of all ones to offset 3, show that neither write reaches the status bits.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_NONE = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_POL  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_ST0  = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 2'd3;
  localparam int MODE_KEY_BIT = 7;
  localparam int STRAP_BIT    = 4;
  typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/irq_chan_latch.sv
module irq_chan_latch (
  input  logic clk,
  input  logic rst,
  input  logic drv_irq,
  input  logic xfer_done,
  input  logic xfer_clr,
  input  logic mask,
  input  logic pol_low,
  output logic drv_st,
  output logic bm_st,
  output logic irq_pin
);
  logic req_any;
  assign req_any = (drv_st | bm_st) & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_st  <= 1'b0;
      bm_st   <= 1'b0;
      irq_pin <= 1'b0;
    end else begin
      drv_st  <= drv_irq;
      if (xfer_done)     bm_st <= 1'b1;
      else if (xfer_clr) bm_st <= 1'b0;
      irq_pin <= req_any ^ pol_low;
    end
  end

  assert_bm_set_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> bm_st);
  assert_bm_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (bm_st && !xfer_clr) |=> bm_st);
  assert_drv_follow_R6: assert property (@(posedge clk) disable iff (rst)
    drv_irq |=> drv_st);
  assert_mask_idle_R8: assert property (@(posedge clk) disable iff (rst)
    mask |=> (irq_pin == $past(pol_low)));
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  ch_vec_t           drv_st,
  input  ch_vec_t           bm_st,
  input  logic              legacy_strap,
  output ch_vec_t           mask_q,
  output ch_vec_t           pol_q,
  output logic              legacy_mode,
  output logic              test_mode,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_POL: rd_mux[NUM_CH-1:0] = pol_q;
      OFS_ST0: rd_mux[1:0] = {bm_st[0], drv_st[0]};
      OFS_MSK: begin
        rd_mux[STRAP_BIT] = legacy_strap;
        rd_mux[3:0]       = {bm_st[1], drv_st[1], mask_q};
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '0;
      pol_q       <= '0;
      legacy_mode <= 1'b0;
      test_mode   <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      if (wr_en) begin
        case (addr)
          OFS_POL: pol_q  <= wr_data[NUM_CH-1:0];
          OFS_MSK: mask_q <= wr_data[NUM_CH-1:0];
          OFS_ST0: if (wr_data[MODE_KEY_BIT]) begin
            legacy_mode <= wr_data[1];
            test_mode   <= wr_data[0];
          end
          default: ;
        endcase
      end
    end
  end

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
  assert_msk_rsvd_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_MSK) |=> (rd_data[7:5] == 3'b000));
  assert_mode_key_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_ST0 && !wr_data[MODE_KEY_BIT]) |=>
      ($stable(legacy_mode) && $stable(test_mode)));
endmodule

// File: rtl/ide_irq_collect.sv
module ide_irq_collect
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] drv_irq,
  input  logic [NUM_CH-1:0] xfer_done,
  input  logic [NUM_CH-1:0] xfer_clr,
  input  logic              legacy_strap,
  output logic              legacy_mode,
  output logic              test_mode,
  output logic [NUM_CH-1:0] irq_pin
);
  ch_vec_t drv_st, bm_st, mask_q, pol_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_latch u_ch (
      .clk       (clk),
      .rst       (rst),
      .drv_irq   (drv_irq[c]),
      .xfer_done (xfer_done[c]),
      .xfer_clr  (xfer_clr[c]),
      .mask      (mask_q[c]),
      .pol_low   (pol_q[c]),
      .drv_st    (drv_st[c]),
      .bm_st     (bm_st[c]),
      .irq_pin   (irq_pin[c])
    );
  end

  irq_reg_file u_regs (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .drv_st       (drv_st),
    .bm_st        (bm_st),
    .legacy_strap (legacy_strap),
    .mask_q       (mask_q),
    .pol_q        (pol_q),
    .legacy_mode  (legacy_mode),
    .test_mode    (test_mode),
    .rd_data      (rd_data)
  );

  assert_st_wr_isolated_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_ST0 && xfer_done == '0 && xfer_clr == '0) |=>
      (bm_st == $past(bm_st)));
  assert_msk_wr_isolated_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_MSK && xfer_done == '0 && xfer_clr == '0) |=>
      (bm_st == $past(bm_st)));
endmodule

// File: tb/ide_irq_collect_tb.sv
module ide_irq_collect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] drv_irq = '0, xfer_done = '0, xfer_clr = '0;
  logic legacy_strap = 1'b1;
  logic legacy_mode, test_mode;
  logic [1:0] irq_pin;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  ide_irq_collect dut_i (.*);

  // behavioural reference, one step per clock
  int m_drv[2], m_bm[2], m_mask[2], m_pol[2], m_irq[2];
  int m_leg, m_tst, m_rd;

  function automatic int ref_read(int a);
    case (a)
      1: return m_pol[1] * 2 + m_pol[0];
      2: return m_bm[0] * 2 + m_drv[0];
      3: return (legacy_strap ? 16 : 0) + m_bm[1] * 8 + m_drv[1] * 4
                + m_mask[1] * 2 + m_mask[0];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nd[2], nb[2], ni[2], nrd;
    nrd = rd_en ? ref_read(int'(addr)) : 0;
    for (int c = 0; c < 2; c++) begin
      nd[c] = drv_irq[c];
      nb[c] = xfer_done[c] ? 1 : (xfer_clr[c] ? 0 : m_bm[c]);
      ni[c] = (((m_drv[c] | m_bm[c]) & (1 - m_mask[c])) != 0) ? 1 - m_pol[c] : m_pol[c];
    end
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_drv[c] = 0; m_bm[c] = 0; m_mask[c] = 0; m_pol[c] = 0; m_irq[c] = 0;
      end
      m_leg = 0; m_tst = 0; m_rd = 0;
    end else begin
      if (wr_en && addr == 2'd1) begin m_pol[0] = wr_data[0]; m_pol[1] = wr_data[1]; end
      if (wr_en && addr == 2'd3) begin m_mask[0] = wr_data[0]; m_mask[1] = wr_data[1]; end
      if (wr_en && addr == 2'd2 && wr_data[7]) begin m_leg = wr_data[1]; m_tst = wr_data[0]; end
      for (int c = 0; c < 2; c++) begin
        m_drv[c] = nd[c]; m_bm[c] = nb[c]; m_irq[c] = ni[c];
      end
      m_rd = nrd;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    chk("irq_pin[0]", int'(irq_pin[0]), m_irq[0]); // R10
    chk("irq_pin[1]", int'(irq_pin[1]), m_irq[1]); // R10
    chk("rd_data", int'(rd_data), m_rd);           // R11
    chk("legacy_mode", int'(legacy_mode), m_leg);
    chk("test_mode", int'(test_mode), m_tst);
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(logic [1:0] a, int exp);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("direct read", int'(rd_data), exp);
  endtask
  task automatic pulse_done(logic [1:0] d, logic [1:0] c);
    xfer_done = d; xfer_clr = c;
    @(negedge clk); xfer_done = '0; xfer_clr = '0;
  endtask

  initial begin
    tag = "R1"; idle(3); @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", int'(irq_pin), 0);
    rd(2'd3, 8'h10); // R1 masks zero, strap shown
    idle(1);
    tag = "R6"; drv_irq = 2'b01; idle(1);
    rd(2'd2, 8'h01); // R2 drive bit 0
    drv_irq = 2'b10; idle(1);
    rd(2'd3, 8'h14); // R4 drive bit 2
    drv_irq = 2'b11; @(negedge clk); drv_irq = 2'b00; idle(3); // glitch
    rd(2'd2, 8'h00);
    tag = "R7"; pulse_done(2'b01, 2'b00); idle(4);
    rd(2'd2, 8'h02);
    pulse_done(2'b00, 2'b01); rd(2'd2, 8'h00);
    pulse_done(2'b11, 2'b11); rd(2'd3, 8'h18); // set wins
    rd(2'd2, 8'h02);
    tag = "R3"; wr(2'd2, 8'h83); idle(1);
    chk("R3 legacy_mode", int'(legacy_mode), 1);
    chk("R3 test_mode", int'(test_mode), 1);
    rd(2'd2, 8'h02);
    wr(2'd2, 8'h00); wr(2'd2, 8'h7C); idle(1);
    chk("R3 keyless ignored", int'({legacy_mode, test_mode}), 3);
    wr(2'd2, 8'h82); rd(2'd2, 8'h02);
    tag = "R5"; wr(2'd3, 8'hF3); rd(2'd3, 8'h1B);
    wr(2'd3, 8'h0C); rd(2'd3, 8'h18);
    pulse_done(2'b00, 2'b11); idle(1);
    wr(2'd3, 8'h0C); rd(2'd3, 8'h10);
    tag = "R8"; wr(2'd3, 8'h03); pulse_done(2'b11, 2'b00); drv_irq = 2'b11; idle(3);
    chk("R8 masked pins", int'(irq_pin), 0);
    rd(2'd3, 8'h1F); rd(2'd2, 8'h03);
    wr(2'd3, 8'h01); idle(2);
    chk("R8 ch1 unmasked", int'(irq_pin), 2);
    tag = "R9"; wr(2'd1, 8'hFF); rd(2'd1, 8'h03); idle(1);
    chk("R9 inverted", int'(irq_pin), 1);
    drv_irq = 2'b00; pulse_done(2'b00, 2'b11); idle(3);
    chk("R9 idle low-active", int'(irq_pin), 3);
    legacy_strap = 1'b0; wr(2'd3, 8'h00); wr(2'd1, 8'h01);
    tag = "R11"; rd(2'd0, 0); rd(2'd3, 8'h00);
    tag = "R10"; drv_irq = 2'b10; idle(4); drv_irq = 2'b00; idle(4);
    tag = "R1"; rst = 1'b1; idle(2); rst = 1'b0; idle(2);
    chk("R1 reset again", int'({legacy_mode, test_mode, irq_pin}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule